// File: doc/BRIEF.md
# Lexicographic constrained-code encoder

This block turns a binary message into a word of `N` multi-level cell symbols, each a level from 0 to `R-1`. The words it can emit are exactly the length-`N` sequences in which a top-level symbol (`R-1`) is never followed by a short run of 1 to `y` lower levels and then by another top-level symbol. Such a pattern stores the most charge in the outer cells and less in the inner ones, and forbidding it protects the write against interference between cells. The word chosen is the one whose rank, among all allowed sequences in dictionary order, equals the message plus one. A decoder that ranks the word gives back the message.

The run limit `y` can be changed at runtime through a select input, up to the build-time maximum `YMAX`. The encoder emits one symbol per cycle, most significant position first. At each position it chooses a level by comparing the remaining rank against multiples of one precomputed count: the number of allowed completions that follow a lower level. It then subtracts the chosen multiple. Count tables for every supported `y` are constants, and the runtime `y` only steers a multiplexer. No multiplier is needed. The all-zero word and the all-top word serve as timing references, and the message width is chosen so that neither is ever produced.

Top module: `qloco_enc`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `sym_valid` are 0 and `code` is all zeros.
- R2: Order all allowed length-`N` level sequences in dictionary order, with the first emitted symbol most significant and level 0 the smallest. A message `m` produces the sequence at rank `m+1` in that order (rank 0 is the first sequence), for the run limit sampled at start.
- R3: No emitted word contains a level `R-1` symbol, followed by between 1 and `y` symbols below `R-1`, followed by another level `R-1` symbol. Adjacent top-level symbols are allowed.
- R4: The all-zero word and the word with every symbol at level `R-1` are never emitted, for any message, including message 0 and the all-ones message.
- R5: A `start` seen while idle begins an encoding. `busy` is high for exactly `N` cycles after that edge. The symbols appear on `sym` with `sym_valid` high, one per cycle, with the most significant symbol first. `done` is a one-cycle pulse in the same cycle as the last symbol. From then on, `code` holds the whole word, with the first symbol in its top `BW` bits.
- R6: A `start` raised while `busy` is high has no effect on the word being produced, and it is not queued.
- R7: `ysel` is sampled only on the starting edge. The value 0 is taken as 1, and values above `YMAX` are taken as `YMAX`. Changes to `ysel` during an encoding do not alter the word.
- R8: The message is `floor(log2(K-2))` bits wide, where `K` is the number of allowed words of length `N` for run limit `YMAX`.
- R9: With `R=2`, `N=4` and `y=1`, message 0 gives `0001`, message 6 gives `1000` and message 7 gives `1001`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin encoding `msg` when idle |
| msg | input | MW | Message value |
| ysel | input | YSW | Requested run limit, clamped to 1..YMAX |
| busy | output | 1 | Encoding in progress |
| done | output | 1 | One-cycle pulse with the last symbol |
| sym_valid | output | 1 | `sym` carries a new symbol this cycle |
| sym | output | BW | Current symbol level |
| code | output | N*BW | Complete word, first symbol in the top bits |

## Verification
A wrong remaining-rank register or a wrong count-table entry changes the symbol chosen at that position and every symbol after it. The word then ranks to a value other than message plus one, and this is visible at `done`, `N+1` cycles after the start edge. A wrong distance-to-top-level state shows up either as a forbidden top-lower-top pattern in the streamed symbols, or as a rank error in the same word. An error in the position counter or in the handshake moves `done` away from the cycle of the last `sym_valid`, or changes the number of symbols streamed.

// File: rtl/qloco_pkg.sv
package qloco_pkg;

  // Number of allowed suffixes of length k when the encoder sits in state st.
  // st = 0      : free, a top level may come next
  // st = 1..y   : st more symbols must stay below the top level
  // st = y + 1  : the previous symbol was the top level
  function automatic longint lc_count(int r, int y, int st, int k);
    longint cur [0:16];
    longint nxt [0:16];
    if (y < 1 || y > 15 || st > y + 1) return 0;
    for (int i = 0; i <= 16; i++) begin
      cur[i] = 1;
      nxt[i] = 0;
    end
    for (int s = 0; s < k; s++) begin
      nxt[0] = longint'(r - 1) * cur[0] + cur[y + 1];
      for (int t = 1; t <= y; t++) nxt[t] = longint'(r - 1) * cur[t - 1];
      nxt[y + 1] = longint'(r - 1) * cur[y] + cur[y + 1];
      for (int i = 0; i <= y + 1; i++) cur[i] = nxt[i];
    end
    return cur[st];
  endfunction

  function automatic int lc_flog2(longint v);
    int n;
    n = 0;
    while (v > 1) begin
      v = v >> 1;
      n++;
    end
    return n;
  endfunction

  function automatic int lc_msg_bits(int r, int n, int ymax);
    return lc_flog2(lc_count(r, ymax, 0, n) - 2);
  endfunction

endpackage

// File: rtl/qloco_wtab.sv
module qloco_wtab #(
  parameter int R    = 4,
  parameter int N    = 8,
  parameter int YMAX = 3,
  parameter int IW   = 17,
  parameter int YW   = 2,
  parameter int PW   = 3
) (
  input  logic [YW-1:0] y_i,
  input  logic [YW-1:0] lock_i,
  input  logic [PW-1:0] pos_i,
  output logic [IW-1:0] w_o
);

  logic [IW-1:0] tab [YMAX][YMAX+1][N];

  for (genvar gy = 0; gy < YMAX; gy++) begin : g_y
    for (genvar gt = 0; gt <= YMAX; gt++) begin : g_t
      for (genvar gk = 0; gk < N; gk++) begin : g_k
        localparam longint V = qloco_pkg::lc_count(R, gy + 1, gt, gk);
        assign tab[gy][gt][gk] = IW'(V);
      end
    end
  end

  always_comb begin
    w_o = '0;
    for (int iy = 0; iy < YMAX; iy++)
      for (int it = 0; it <= YMAX; it++)
        for (int ik = 0; ik < N; ik++)
          if (y_i == YW'(iy + 1) && lock_i == YW'(it) && pos_i == PW'(ik))
            w_o = tab[iy][it][ik];
  end

endmodule

// File: rtl/qloco_pick.sv
module qloco_pick #(
  parameter int R  = 4,
  parameter int IW = 17,
  parameter int BW = 2
) (
  input  logic [IW-1:0] rem_i,
  input  logic [IW-1:0] w_i,
  input  logic          max_ok_i,
  output logic [BW-1:0] lvl_o,
  output logic [IW-1:0] sub_o
);

  logic [IW:0] acc;

  always_comb begin
    acc   = '0;
    lvl_o = '0;
    sub_o = '0;
    for (int c = 1; c < R; c++) begin
      acc = acc + {1'b0, w_i};
      if (acc <= {1'b0, rem_i} && (c < R - 1 || max_ok_i)) begin
        lvl_o = BW'(c);
        sub_o = acc[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/qloco_enc.sv
module qloco_enc #(
  parameter int R    = 4,
  parameter int N    = 8,
  parameter int YMAX = 3,
  localparam int BW  = $clog2(R),
  localparam int MW  = qloco_pkg::lc_msg_bits(R, N, YMAX),
  localparam int YSW = $clog2(YMAX + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MW-1:0]   msg,
  input  logic [YSW-1:0]  ysel,
  output logic            busy,
  output logic            done,
  output logic            sym_valid,
  output logic [BW-1:0]   sym,
  output logic [N*BW-1:0] code
);

  localparam int IW = BW * N + 1;
  localparam int YW = $clog2(YMAX + 1);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [BW-1:0] MAXL = BW'(R - 1);

  logic [IW-1:0]   rem_q;
  logic [PW-1:0]   pos_q;
  logic [YW-1:0]   lock_q, lock_nm, y_q, ycl;
  logic            aft_q, busy_q, done_q, sv_q;
  logic [BW-1:0]   sym_q, lvl;
  logic [N*BW-1:0] code_q;
  logic [IW-1:0]   wgt, sub;

  // named events for the assertions
  logic max_ok, step_fire, last_step, pick_max;
  assign max_ok    = (lock_q == '0);
  assign step_fire = busy_q;
  assign last_step = busy_q && (pos_q == '0);
  assign pick_max  = (lvl == MAXL);

  always_comb begin
    if (ysel == '0)             ycl = YW'(1);
    else if (int'(ysel) > YMAX) ycl = YW'(YMAX);
    else                        ycl = YW'(ysel);
  end

  always_comb begin
    if (aft_q)              lock_nm = y_q;
    else if (lock_q != '0)  lock_nm = lock_q - 1'b1;
    else                    lock_nm = '0;
  end

  qloco_wtab #(.R(R), .N(N), .YMAX(YMAX), .IW(IW), .YW(YW), .PW(PW)) u_wtab (
    .y_i(y_q), .lock_i(lock_nm), .pos_i(pos_q), .w_o(wgt)
  );

  qloco_pick #(.R(R), .IW(IW), .BW(BW)) u_pick (
    .rem_i(rem_q), .w_i(wgt), .max_ok_i(max_ok), .lvl_o(lvl), .sub_o(sub)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pos_q  <= '0;
      lock_q <= '0;
      y_q    <= YW'(1);
      aft_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sv_q   <= 1'b0;
      sym_q  <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      sv_q   <= 1'b0;
      if (step_fire) begin
        sym_q  <= lvl;
        sv_q   <= 1'b1;
        code_q <= {code_q[N*BW-BW-1:0], lvl};
        rem_q  <= rem_q - sub;
        if (pick_max) begin
          aft_q  <= 1'b1;
          lock_q <= '0;
        end else begin
          aft_q  <= 1'b0;
          lock_q <= lock_nm;
        end
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pos_q <= pos_q - 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        rem_q  <= IW'(msg) + IW'(1);
        pos_q  <= PW'(N - 1);
        lock_q <= '0;
        aft_q  <= 1'b0;
        y_q    <= ycl;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign sym_valid = sv_q;
  assign sym       = sym_q;
  assign code      = code_q;

  // R2: the whole rank is consumed once the last symbol is out
  p_rem_spent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q == '0));

  // R3: inside a guarded gap the top level is never chosen
  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && lock_q != '0) |-> !pick_max);

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: busy drops exactly when done rises
  p_fell_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R5: a symbol only follows a busy cycle
  p_sv_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sv_q |-> $past(busy_q));

  // R6: while busy the position only walks down, start cannot reload it
  p_pos_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pos_q != '0) |=> (busy_q && pos_q == $past(pos_q) - 1'b1));

  // R7: the sampled run limit always lies in the supported range
  p_y_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (y_q != '0 && int'(y_q) <= YMAX));

endmodule

// File: tb/qloco_enc_bench.sv
`timescale 1ns/1ps
module qloco_enc_bench;

  localparam int R    = 4;
  localparam int N    = 8;
  localparam int YMAX = 3;
  localparam int BW   = $clog2(R);
  localparam int MW   = qloco_pkg::lc_msg_bits(R, N, YMAX);
  localparam int YSW  = $clog2(YMAX + 2);

  localparam int MW2  = qloco_pkg::lc_msg_bits(2, 4, 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            start = 1'b0;
  logic [MW-1:0]   msg = '0;
  logic [YSW-1:0]  ysel = '0;
  logic            busy, done, sym_valid;
  logic [BW-1:0]   sym;
  logic [N*BW-1:0] code;

  logic            b_start = 1'b0;
  logic [MW2-1:0]  b_msg = '0;
  logic [1:0]      b_ysel = 2'd1;
  logic            b_busy, b_done, b_sv;
  logic            b_sym;
  logic [3:0]      b_code;

  int nchk = 0;
  int nfail = 0;

  qloco_enc #(.R(R), .N(N), .YMAX(YMAX)) u_qloco_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .msg(msg), .ysel(ysel),
    .busy(busy), .done(done), .sym_valid(sym_valid), .sym(sym), .code(code)
  );

  qloco_enc #(.R(2), .N(4), .YMAX(1)) u_qloco_enc_bin (
    .clk(clk), .rst_n(rst_n), .start(b_start), .msg(b_msg), .ysel(b_ysel),
    .busy(b_busy), .done(b_done), .sym_valid(b_sv), .sym(b_sym), .code(b_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // suffix count, state = symbols since the last top level (y+1: unrestricted)
  function automatic longint tb_paths(int r, int y, int g0, int k);
    longint c [0:17];
    longint nx [0:17];
    for (int g = 0; g <= 17; g++) begin
      c[g] = 1;
      nx[g] = 0;
    end
    for (int s = 0; s < k; s++) begin
      for (int g = 0; g <= y + 1; g++) begin
        int gn;
        gn = (g + 1 > y + 1) ? y + 1 : g + 1;
        nx[g] = longint'(r - 1) * c[gn] + ((g == 0 || g == y + 1) ? c[0] : 0);
      end
      for (int g = 0; g <= y + 1; g++) c[g] = nx[g];
    end
    return c[g0];
  endfunction

  // rank of a word and whether it respects the gap rule
  function automatic longint tb_rank(input logic [N*BW-1:0] cw, input int y,
                                     output bit legal);
    longint rk;
    int g;
    rk = 0;
    g = y + 1;
    legal = 1'b1;
    for (int p = N - 1; p >= 0; p--) begin
      int d;
      int gn;
      d = int'(cw[p*BW +: BW]);
      gn = (g + 1 > y + 1) ? y + 1 : g + 1;
      rk += longint'(d) * tb_paths(R, y, gn, p);
      if (d == R - 1) begin
        if (!(g == 0 || g == y + 1)) legal = 1'b0;
        g = 0;
      end else begin
        g = gn;
      end
    end
    return rk;
  endfunction

  task automatic run_main(input logic [MW-1:0] m, input int ys,
                          input bit restart, input bit disturb);
    int y;
    logic [N*BW-1:0] got;
    longint rk;
    bit legal;
    y = (ys == 0) ? 1 : ((ys > YMAX) ? YMAX : ys);
    got = '0;
    @(negedge clk);
    msg = m;
    ysel = YSW'(ys);
    start = 1'b1;
    @(negedge clk);
    start = restart;
    if (restart) msg = ~m;
    if (disturb) ysel = ysel ^ YSW'(5);
    chk(busy && !sym_valid, "R5", "busy after start", longint'(busy), 1);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(sym_valid == 1'b1, "R5", "sym_valid per cycle", longint'(sym_valid), 1);
      got = {got[N*BW-BW-1:0], sym};
      if (i == N - 1) chk(done && !busy, "R5", "done with last symbol", longint'(done), 1);
      else            chk(!done && busy, "R5", "no early done", longint'(done), 0);
    end
    chk(code == got, "R5", "code matches stream", longint'(code), longint'(got));
    rk = tb_rank(code, y, legal);
    chk(legal, "R3", "gap rule", longint'(code), 0);
    chk(rk == longint'(m) + 1, restart ? "R6" : (disturb ? "R7" : "R2"),
        "rank", rk, longint'(m) + 1);
    chk(code != '0 && code != '1, "R4", "reference words excluded", longint'(code), 1);
    @(negedge clk);
    chk(!done && !sym_valid, "R5", "done pulse length", longint'(done), 0);
  endtask

  task automatic run_bin(input logic [MW2-1:0] m, input logic [3:0] exp);
    @(negedge clk);
    b_msg = m;
    b_start = 1'b1;
    @(negedge clk);
    b_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(b_done == 1'b1, "R9", "binary done", longint'(b_done), 1);
    chk(b_code == exp, "R9", "binary word", longint'(b_code), longint'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog: actual %0d cycles expected fewer", 100000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d5e;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sym_valid && code == '0, "R1", "reset state", longint'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !sym_valid && code == '0, "R1", "after release", longint'(code), 0);
    chk(!b_busy && b_code == 4'd0, "R1", "binary after release", longint'(b_code), 0);

    chk(MW == qloco_pkg::lc_flog2(tb_paths(R, YMAX, YMAX + 1, N) - 2),
        "R8", "message width", MW, qloco_pkg::lc_flog2(tb_paths(R, YMAX, YMAX + 1, N) - 2));
    chk(MW2 == 3, "R8", "binary message width", MW2, 3);

    run_bin(3'd0, 4'b0001);
    run_bin(3'd6, 4'b1000);
    run_bin(3'd7, 4'b1001);

    run_main('0, 1, 0, 0);
    run_main('0, 3, 0, 0);
    run_main('1, 1, 0, 0);
    run_main('1, 3, 0, 0);
    run_main(MW'(12345), 0, 0, 0);
    run_main(MW'(777), 7, 0, 0);
    run_main(MW'(4242), 2, 1, 0);
    run_main(MW'(999), 1, 0, 1);
    run_main(MW'(31000), 3, 0, 1);

    for (int k = 0; k < 40; k++) begin
      run_main(MW'($urandom), int'($urandom % 6), ($urandom % 4) == 0, ($urandom % 4) == 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule